// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

An 8-bit arithmetic and logic unit that keeps its own accumulator and a helper register. Each cycle where `op_valid` is high, the unit reads a 4-bit operation code and one source byte. It writes a new accumulator value, updates the helper register where the operation uses it, and refreshes the carry, half-carry and overflow flags. A parity flag is derived from the accumulator at all times. Instruction decode and operand fetch sit upstream: a sequencer hands this block one operation per cycle and reads back the registered results.

Operations cover plain add, add including carry, subtract including borrow, bitwise AND/OR/XOR, clear, complement, one-bit rotates in either direction, increment, decrement, an unsigned 8x8 multiply and an unsigned 8/8 divide. A load operation fills the helper register so that it can act as the second operand of multiply and divide. All state is held in flops that reset synchronously. Results appear on the outputs on the clock edge that accepts the operation.

Top module: `acc_alu_core`

## Requirements
- R1: Operation codes are NOP=0, ADD=1, ADDC=2, SUBB=3, AND=4, OR=5, XOR=6, CLR=7, CPL=8, RL=9, RR=10, INC=11, DEC=12, MUL=13, DIV=14, LDB=15. A synchronous active-high reset clears the accumulator, the helper register and all flags. Every accepted operation shows its result on the outputs after the next rising clock edge.
- R2: ADD writes A+src to A. ADDC writes A+src+CY to A. Plain ADD ignores the carry flag. Both set CY to the carry out of bit 7.
- R3: After ADD, ADDC and SUBB, AC equals the carry (or borrow) between bit 3 and bit 4 of that same operation.
- R4: After ADD, ADDC and SUBB, OV is 1 exactly when the signed two's-complement result leaves the range -128..127.
- R5: SUBB writes A-src-CY to A. It sets CY when the operation borrows into bit 7, that is, when A < src+CY unsigned.
- R6: The parity output is 1 when the accumulator holds an odd number of ones, and 0 otherwise, in every cycle.
- R7: AND, OR and XOR combine A with src. INC and DEC add or subtract one, with wrap-around. None of these five changes CY, AC or OV.
- R8: RL moves every bit of A one place up and bit 7 into bit 0. RR moves every bit one place down and bit 0 into bit 7. Neither touches the flags.
- R9: CLR writes 00h to A, and CPL inverts every bit of A. Neither changes the flags.
- R10: MUL forms A*B. It writes the low byte to A and the high byte to B, sets OV when the product exceeds 255, clears CY and leaves AC unchanged.
- R11: DIV writes the quotient of A/B to A and the remainder to B, clearing CY and OV. When B is zero, it sets OV, clears CY and leaves A and B unchanged.
- R12: LDB copies src into B and leaves A and the flags alone. A cycle with op_valid low changes nothing, whatever op_code holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector (encoding in R1) |
| src | input | DW (8) | Source byte from a register or an immediate |
| acc_o | output | DW (8) | Accumulator A |
| b_o | output | DW (8) | Helper register B |
| cy_o | output | 1 | Carry / borrow flag |
| ac_o | output | 1 | Half-carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Odd parity of A |

## Verification
Every result sits exactly one register stage behind its operation. A, B and the three flags change on the rising edge that accepts the operation. Parity follows A with no extra stage. The bench drives each operation on a falling edge and compares all six outputs on the very next falling edge, half a period after the single register has loaded. This exposes any added or missing pipeline stage. The vector table chains its operations so that the carry produced by one row feeds the next row. In that way ADDC, SUBB and the flag-preserving operations are each checked against a known incoming flag state.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUBB = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CLR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_RL   = 4'd9,
        OP_RR   = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_MUL  = 4'd13,
        OP_DIV  = 4'd14,
        OP_LDB  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;

    // Operations whose result comes from the bitwise/shift unit and keep all flags
    function automatic logic keeps_flags(input alu_op_e op);
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL,
            OP_RL, OP_RR, OP_INC, OP_DEC: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          cy,
    output logic          ac,
    output logic          ov
);
    localparam int HALF = DW / 2;
    localparam int MSB  = DW - 1;

    logic [DW:0]   full;
    logic [HALF:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
        res = full[DW-1:0];
        cy  = full[DW];
        ac  = low[HALF];
        if (sub)
            ov = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
        else
            ov = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] mul_lo,
    output logic [DW-1:0] mul_hi,
    output logic          mul_ov,
    output logic [DW-1:0] div_q,
    output logic [DW-1:0] div_r,
    output logic          div_zero
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] prod;

    always_comb begin
        prod   = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        mul_lo = prod[DW-1:0];
        mul_hi = prod[PW-1:DW];
        mul_ov = |mul_hi;

        div_zero = (b == '0);
        if (div_zero) begin
            // hold both operands so the registers stay stable
            div_q = a;
            div_r = b;
        end else begin
            div_q = a / b;
            div_r = a % b;
        end
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] res
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    always_comb begin
        case (op)
            OP_AND:  res = a & src;
            OP_OR:   res = a | src;
            OP_XOR:  res = a ^ src;
            OP_CLR:  res = '0;
            OP_CPL:  res = ~a;
            OP_RL:   res = {a[DW-2:0], a[DW-1]};
            OP_RR:   res = {a[0], a[DW-1:1]};
            OP_INC:  res = a + ONE;
            OP_DEC:  res = a - ONE;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] b_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          ov_o,
    output logic          par_o
);
    localparam int MSB = DW - 1;

    alu_op_e    op;
    logic [DW-1:0] acc_q, b_q, acc_n, b_n;
    alu_flags_t flg_q, flg_n;

    logic [DW-1:0] as_res, bo_res, mul_lo, mul_hi, div_q, div_r;
    logic          as_cy, as_ac, as_ov, mul_ov, div_zero, as_cin;

    assign op     = alu_op_e'(op_code);
    assign as_cin = (op == OP_ADD) ? 1'b0 : flg_q.cy;

    alu_addsub #(.DW(DW)) u_addsub (
        .a(acc_q), .b(src), .cin(as_cin), .sub(op == OP_SUBB),
        .res(as_res), .cy(as_cy), .ac(as_ac), .ov(as_ov)
    );

    alu_muldiv #(.DW(DW)) u_muldiv (
        .a(acc_q), .b(b_q),
        .mul_lo(mul_lo), .mul_hi(mul_hi), .mul_ov(mul_ov),
        .div_q(div_q), .div_r(div_r), .div_zero(div_zero)
    );

    alu_bitops #(.DW(DW)) u_bitops (
        .op(op), .a(acc_q), .src(src), .res(bo_res)
    );

    always_comb begin
        acc_n = acc_q;
        b_n   = b_q;
        flg_n = flg_q;
        if (op_valid) begin
            if (is_arith(op)) begin
                acc_n    = as_res;
                flg_n.cy = as_cy;
                flg_n.ac = as_ac;
                flg_n.ov = as_ov;
            end else if (keeps_flags(op)) begin
                acc_n = bo_res;
            end else begin
                case (op)
                    OP_MUL: begin
                        acc_n    = mul_lo;
                        b_n      = mul_hi;
                        flg_n.cy = 1'b0;
                        flg_n.ov = mul_ov;
                    end
                    OP_DIV: begin
                        acc_n    = div_q;
                        b_n      = div_r;
                        flg_n.cy = 1'b0;
                        flg_n.ov = div_zero;
                    end
                    OP_LDB:  b_n = src;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            b_q   <= '0;
            flg_q <= '0;
        end else begin
            acc_q <= acc_n;
            b_q   <= b_n;
            flg_q <= flg_n;
        end
    end

    assign acc_o = acc_q;
    assign b_o   = b_q;
    assign cy_o  = flg_q.cy;
    assign ac_o  = flg_q.ac;
    assign ov_o  = flg_q.ov;
    assign par_o = ^acc_q;

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_CLR) |=> (acc_o == '0));

    // R9
    cpl_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_CPL) |=> (acc_o == ~$past(acc_o)));

    // R8
    rl_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_RL) |=> (acc_o == {$past(acc_o[MSB-1:0]), $past(acc_o[MSB])}));

    // R7
    flags_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && keeps_flags(op)) |=> ($stable(cy_o) && $stable(ac_o) && $stable(ov_o)));

    // R10
    mul_carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_MUL) |=> (!cy_o && $stable(ac_o)));

    // R11
    div_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_DIV && b_o == '0) |=> (ov_o && !cy_o && $stable(acc_o) && $stable(b_o)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_o) && $stable(b_o) && $stable(cy_o) && $stable(ov_o)));

    // R12
    ldb_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_LDB) |=> ($stable(acc_o) && b_o == $past(src)));
endmodule

// File: tb/acc_alu_core_tb_top.sv
`timescale 1ns/1ps
module acc_alu_core_tb_top;
    import acc_alu_pkg::*;

    typedef struct packed {
        alu_op_e    op;
        logic [7:0] src;
        logic [7:0] a;
        logic [7:0] b;
        logic       cy;
        logic       ac;
        logic       ov;
        logic       p;
    } vec_t;

    localparam int NV = 29;
    // rows chain: each expected state is the start of the next row (R3, R4, R6 checked on every row)
    localparam vec_t TBL [0:NV-1] = '{
        '{OP_ADD,  8'h3A, 8'h3A, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        '{OP_ADD,  8'hC6, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_ADDC, 8'h7F, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
        '{OP_SUBB, 8'h01, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
        '{OP_XOR,  8'hFF, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
        '{OP_SUBB, 8'h90, 8'hF0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
        '{OP_ADDC, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_INC,  8'h00, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1},
        '{OP_DEC,  8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_DEC,  8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_AND,  8'h5A, 8'h5A, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_RL,   8'h00, 8'hB4, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_RR,   8'h00, 8'h5A, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_CPL,  8'h00, 8'hA5, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_RR,   8'h00, 8'hD2, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_LDB,  8'h10, 8'hD2, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0},
        '{OP_MUL,  8'h00, 8'h20, 8'h0D, 1'b0, 1'b1, 1'b1, 1'b1},
        '{OP_LDB,  8'h07, 8'h20, 8'h07, 1'b0, 1'b1, 1'b1, 1'b1},
        '{OP_CLR,  8'h00, 8'h00, 8'h07, 1'b0, 1'b1, 1'b1, 1'b0},
        '{OP_ADD,  8'h64, 8'h64, 8'h07, 1'b0, 1'b0, 1'b0, 1'b1},
        '{OP_DIV,  8'h00, 8'h0E, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1},
        '{OP_LDB,  8'h00, 8'h0E, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
        '{OP_DIV,  8'h00, 8'h0E, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
        '{OP_LDB,  8'h03, 8'h0E, 8'h03, 1'b0, 1'b0, 1'b1, 1'b1},
        '{OP_MUL,  8'h00, 8'h2A, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
        '{OP_OR,   8'h81, 8'hAB, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
        '{OP_ADD,  8'h80, 8'h2B, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
        '{OP_CPL,  8'h00, 8'hD4, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
        '{OP_RL,   8'h00, 8'hA9, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] src = 8'h00;
    logic [7:0] acc_o, b_o;
    logic       cy_o, ac_o, ov_o, par_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    acc_alu_core #(.DW(8)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .src(src),
        .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o)
    );

    function automatic string req_of(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC:                        return "R2";
            OP_SUBB:                                return "R5";
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:  return "R7";
            OP_RL, OP_RR:                           return "R8";
            OP_CLR, OP_CPL:                         return "R9";
            OP_MUL:                                 return "R10";
            OP_DIV:                                 return "R11";
            default:                                return "R12";
        endcase
    endfunction

    task automatic expect_state(input string tag, input logic [7:0] ea, input logic [7:0] eb,
                                input logic ecy, input logic eac, input logic eov, input logic ep);
        n_chk++;
        if (acc_o !== ea || b_o !== eb || cy_o !== ecy || ac_o !== eac || ov_o !== eov || par_o !== ep) begin
            n_bad++;
            $display("FAIL %s: actual A=%h B=%h cy=%b ac=%b ov=%b p=%b expected A=%h B=%h cy=%b ac=%b ov=%b p=%b",
                     tag, acc_o, b_o, cy_o, ac_o, ov_o, par_o, ea, eb, ecy, eac, eov, ep);
        end
    endtask

    task automatic issue(input alu_op_e op, input logic [7:0] s);
        op_valid = 1'b1;
        op_code  = 4'(op);
        src      = s;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog R1: actual run not finished expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        expect_state("R1 reset", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].src);
            expect_state($sformatf("%s R3 R4 R6 row %0d %s", req_of(TBL[i].op), i, TBL[i].op.name()),
                         TBL[i].a, TBL[i].b, TBL[i].cy, TBL[i].ac, TBL[i].ov, TBL[i].p);
        end

        // R12: op_valid low with CLR on op_code has no effect
        op_valid = 1'b0;
        op_code  = 4'(OP_CLR);
        src      = 8'h55;
        @(negedge clk);
        expect_state("R12 idle", 8'hA9, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);

        // R1: reset mid-run returns to all zero
        rst = 1'b1;
        @(negedge clk);
        expect_state("R1 rerun reset", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        // R2: plain add ignores a set carry
        issue(OP_ADD, 8'hFF);
        expect_state("R2 add ff", 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(OP_ADD, 8'h01);
        expect_state("R2 R3 wrap", 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        issue(OP_ADD, 8'h05);
        expect_state("R2 carry ignored", 8'h05, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

        // R5 R4: 0x05 - 0x06 borrows, no signed overflow
        issue(OP_SUBB, 8'h06);
        expect_state("R5 borrow", 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);

        // R11: 0xFF / 0x01 with carry set on entry -> carry cleared
        issue(OP_LDB, 8'h01);
        issue(OP_DIV, 8'h00);
        expect_state("R11 div by one", 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule